// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as a plain count of seconds. It runs directly on a slow timebase clock (nominally 32.768 kHz). A free-running prescaler advances once per clock while the counter runs. Each time a chosen prescaler bit falls from one to zero, the seconds count steps by one. Software converts the seconds count to and from a calendar date itself.

An alarm compare register raises a flag when the count steps away from the stored value. A wrap of the seconds count past all-ones raises an overflow flag. An invalid-time flag is set by power-on reset and by soft reset. While either the invalid or the overflow flag is set, the time is treated as untrustworthy: the count and the prescaler freeze and read back as zero until software reloads the seconds count.

Three level interrupts each combine a flag with its own enable. A one-cycle pulse marks every step of the count and needs no acknowledgement. A single-cycle write strobe and a combinational read port give software access to the registers.

Top module: `secs_alarm_timer`

## Requirements
- R1: After reset, the block is in a known state. The status register (address 3) reads 1, meaning only the invalid flag (bit 0) is set. Every other register reads 0, and all four outputs are low. The register addresses are: seconds 0, prescaler 1, alarm 2, status 3, interrupt enable 4, control 5.
- R2: The block advances only while the run bit (status bit 4) is set and both the invalid and overflow flags are clear. In that state the prescaler increases by one every clock. The seconds count increases by one on the clock where prescaler bit TAP changes from 1 to 0.
- R3: While the run bit is set, writes to the seconds register and to the prescaler are ignored.
- R4: While the run bit is clear, the seconds register and the prescaler take written values, and neither one advances.
- R5: A write to the seconds register while the run bit is clear clears both the invalid flag (status bit 0) and the overflow flag (status bit 1).
- R6: While the invalid or overflow flag is set, the seconds register and the prescaler read as zero. Their stored values do not change, and become visible again once the flags are cleared.
- R7: The alarm flag (status bit 2) is set when the seconds count increments from a value equal to the alarm register. Any write to the alarm register clears the alarm flag.
- R8: The overflow flag is set when the seconds count wraps from all-ones to zero.
- R9: `secPulse` is high for exactly one cycle. That cycle is the first cycle in which the incremented seconds value is visible, and the pulse occurs once per increment.
- R10: Each interrupt output is high when its flag is set and its enable is set. The enable bits are: bit 0 for the alarm interrupt, bit 1 for the overflow interrupt, and bit 2 for the invalid interrupt.
- R11: Writing 1 to control bit 0 starts a soft reset. From the next cycle, every other register and flag is held at its R1 value and writes to them are ignored. The control bit stays set until software writes 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| regAddr | input | 3 | Register address for reads and writes |
| regWr | input | 1 | Write strobe, one cycle per write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for regAddr, combinational |
| secPulse | output | 1 | One-cycle pulse on each seconds increment |
| alarmIrq | output | 1 | Alarm flag AND alarm enable |
| ovfIrq | output | 1 | Overflow flag AND overflow enable |
| invIrq | output | 1 | Invalid flag AND invalid enable |

## Verification
The properties take some facts for granted:
- Each write strobe lasts one cycle and is taken as a single access.
- TAP is at least 1 and lies inside the prescaler, so two pulses can never be adjacent.
- A rise of the alarm flag can only come from an increment, not from a bus write.

The stimulus stays within these limits. It changes inputs only at the falling clock edge and drops the write strobe after one rising edge. It uses a small configuration (8-bit seconds, 5-bit prescaler, tap bit 3), which keeps the wrap and the per-cycle prescaler sequence reachable in a few thousand cycles.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_SECS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PRESC = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ALARM = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd5;

  // status bit positions
  localparam int ST_INV = 0;
  localparam int ST_OVF = 1;
  localparam int ST_ALM = 2;
  localparam int ST_RUN = 4;

  // enable bit positions
  localparam int IE_ALM = 0;
  localparam int IE_OVF = 1;
  localparam int IE_INV = 2;
  localparam int IE_W   = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic loadSecs;
    logic loadPresc;
    logic loadAlarm;
    logic advance;
    logic clear;
  } sat_strobe_t;

endpackage

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int PRE_W  = 16,
  parameter int TAP    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  sat_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  secsVal,
  output logic [PRE_W-1:0]  prescVal,
  output logic [SEC_W-1:0]  alarmVal,
  output logic              tick,
  output logic              alarmHit,
  output logic              wrapHit
);

  logic [PRE_W-1:0] prescNext;
  logic [SEC_W-1:0] secsNext;

  assign prescNext = prescVal + PRE_W'(1);
  assign secsNext  = secsVal + SEC_W'(1);

  // a second elapses when the tap bit falls
  assign tick     = strb.advance && prescVal[TAP] && !prescNext[TAP];
  assign alarmHit = tick && (secsVal == alarmVal);
  assign wrapHit  = tick && (&secsVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescVal <= '0;
    end else if (strb.clear) begin
      prescVal <= '0;
    end else if (strb.loadPresc) begin
      prescVal <= wrData[PRE_W-1:0];
    end else if (strb.advance) begin
      prescVal <= prescNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secsVal <= '0;
    end else if (strb.clear) begin
      secsVal <= '0;
    end else if (strb.loadSecs) begin
      secsVal <= wrData[SEC_W-1:0];
    end else if (tick) begin
      secsVal <= secsNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmVal <= '0;
    end else if (strb.clear) begin
      alarmVal <= '0;
    end else if (strb.loadAlarm) begin
      alarmVal <= wrData[SEC_W-1:0];
    end
  end

endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [SEC_W-1:0]  secsVal,
  input  logic [PRE_W-1:0]  prescVal,
  input  logic [SEC_W-1:0]  alarmVal,
  input  logic              tick,
  input  logic              alarmHit,
  input  logic              wrapHit,
  output sat_strobe_t       strb,
  output logic              timeInvalid,
  output logic              timeOverflow,
  output logic              alarmFlag,
  output logic              runBit,
  output logic              softRst,
  output logic              secPulse,
  output logic              alarmIrq,
  output logic              ovfIrq,
  output logic              invIrq
);

  logic [IE_W-1:0] irqEn;
  logic            timeValid;
  logic            wrSecs, wrPresc, wrAlarm, wrStat, wrIen, wrCtrl;

  assign timeValid = !timeInvalid && !timeOverflow;

  assign wrSecs  = regWr && (regAddr == ADR_SECS);
  assign wrPresc = regWr && (regAddr == ADR_PRESC);
  assign wrAlarm = regWr && (regAddr == ADR_ALARM);
  assign wrStat  = regWr && (regAddr == ADR_STAT);
  assign wrIen   = regWr && (regAddr == ADR_IEN);
  assign wrCtrl  = regWr && (regAddr == ADR_CTRL);

  always_comb begin
    strb           = '0;
    strb.clear     = softRst;
    strb.loadSecs  = wrSecs  && !runBit && !softRst;
    strb.loadPresc = wrPresc && !runBit && !softRst;
    strb.loadAlarm = wrAlarm && !softRst;
    strb.advance   = runBit && timeValid && !softRst;
  end

  // soft reset bit: only software clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst <= 1'b0;
    end else if (wrCtrl) begin
      softRst <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeInvalid  <= 1'b1;
      timeOverflow <= 1'b0;
      alarmFlag    <= 1'b0;
      runBit       <= 1'b0;
      irqEn        <= '0;
      secPulse     <= 1'b0;
    end else if (softRst) begin
      timeInvalid  <= 1'b1;
      timeOverflow <= 1'b0;
      alarmFlag    <= 1'b0;
      runBit       <= 1'b0;
      irqEn        <= '0;
      secPulse     <= 1'b0;
    end else begin
      secPulse <= tick;
      if (strb.loadSecs) begin
        timeInvalid  <= 1'b0;
        timeOverflow <= 1'b0;
      end else if (wrapHit) begin
        timeOverflow <= 1'b1;
      end
      if (strb.loadAlarm) begin
        alarmFlag <= 1'b0;
      end else if (alarmHit) begin
        alarmFlag <= 1'b1;
      end
      if (wrStat) begin
        runBit <= wrData[ST_RUN];
      end
      if (wrIen) begin
        irqEn <= wrData[IE_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      ADR_SECS:  rdData = timeValid ? DATA_W'(secsVal) : '0;
      ADR_PRESC: rdData = timeValid ? DATA_W'(prescVal) : '0;
      ADR_ALARM: rdData = DATA_W'(alarmVal);
      ADR_STAT: begin
        rdData[ST_INV] = timeInvalid;
        rdData[ST_OVF] = timeOverflow;
        rdData[ST_ALM] = alarmFlag;
        rdData[ST_RUN] = runBit;
      end
      ADR_IEN:   rdData = DATA_W'(irqEn);
      ADR_CTRL:  rdData = DATA_W'(softRst);
      default:   rdData = '0;
    endcase
  end

  assign alarmIrq = alarmFlag    && irqEn[IE_ALM];
  assign ovfIrq   = timeOverflow && irqEn[IE_OVF];
  assign invIrq   = timeInvalid  && irqEn[IE_INV];

endmodule

// File: rtl/secs_alarm_timer.sv
module secs_alarm_timer
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int PRE_W  = 16,
  parameter int TAP    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              secPulse,
  output logic              alarmIrq,
  output logic              ovfIrq,
  output logic              invIrq
);

  sat_strobe_t      strb;
  logic [SEC_W-1:0] secsVal;
  logic [PRE_W-1:0] prescVal;
  logic [SEC_W-1:0] alarmVal;
  logic             tick, alarmHit, wrapHit;
  logic             timeInvalid, timeOverflow, alarmFlag, runBit, softRst;

  sat_datapath #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .PRE_W(PRE_W), .TAP(TAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .secsVal(secsVal), .prescVal(prescVal), .alarmVal(alarmVal),
    .tick(tick), .alarmHit(alarmHit), .wrapHit(wrapHit)
  );

  sat_ctrl #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .PRE_W(PRE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wrData(wrData), .rdData(rdData),
    .secsVal(secsVal), .prescVal(prescVal), .alarmVal(alarmVal),
    .tick(tick), .alarmHit(alarmHit), .wrapHit(wrapHit),
    .strb(strb), .timeInvalid(timeInvalid), .timeOverflow(timeOverflow),
    .alarmFlag(alarmFlag), .runBit(runBit), .softRst(softRst),
    .secPulse(secPulse), .alarmIrq(alarmIrq), .ovfIrq(ovfIrq),
    .invIrq(invIrq)
  );

endmodule

// File: rtl/sat_checker.sv
module sat_checker
  import sat_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int PRE_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input sat_strobe_t      strb,
  input logic [SEC_W-1:0] secsVal,
  input logic [PRE_W-1:0] prescVal,
  input logic [SEC_W-1:0] alarmVal,
  input logic             timeInvalid,
  input logic             timeOverflow,
  input logic             alarmFlag,
  input logic             softRst,
  input logic             secPulse
);

  p_presc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.advance) && !$past(strb.loadPresc)) |->
      prescVal == PRE_W'($past(prescVal) + 1));

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.advance) && !$past(strb.loadSecs) && !$past(strb.loadPresc)
     && !$past(strb.clear)) |-> ($stable(secsVal) && $stable(prescVal)));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(timeInvalid || timeOverflow) && !$past(strb.loadSecs)
     && !$past(strb.loadPresc) && !$past(strb.clear))
      |-> ($stable(secsVal) && $stable(prescVal)));

  p_alarm_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |->
      ($past(secsVal) == $past(alarmVal) && secsVal != $past(secsVal)));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeOverflow) |-> ((&$past(secsVal)) && secsVal == '0));

  p_pulse_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> secsVal == SEC_W'($past(secsVal) + 1));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> !secPulse);

  p_soft_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(softRst) |-> (timeInvalid && !timeOverflow && !alarmFlag
      && secsVal == '0 && prescVal == '0 && alarmVal == '0));

endmodule

bind secs_alarm_timer sat_checker #(.SEC_W(SEC_W), .PRE_W(PRE_W)) u_sat_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .secsVal(secsVal),
  .prescVal(prescVal), .alarmVal(alarmVal), .timeInvalid(timeInvalid),
  .timeOverflow(timeOverflow), .alarmFlag(alarmFlag), .softRst(softRst),
  .secPulse(secPulse)
);

// File: tb/tb_secs_alarm_timer.sv
`timescale 1ns/1ps
module tb_secs_alarm_timer;

  localparam int DATA_W = 32;
  localparam int SEC_W  = 8;
  localparam int PRE_W  = 5;
  localparam int TAP    = 3;
  localparam int STEP   = 1 << (TAP + 1);
  localparam int PMOD   = 1 << PRE_W;
  localparam int SMOD   = 1 << SEC_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        regAddr = '0;
  logic              regWr = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              secPulse, alarmIrq, ovfIrq, invIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  secs_alarm_timer #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .PRE_W(PRE_W), .TAP(TAP)
  ) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .wrData(wrData), .rdData(rdData), .secPulse(secPulse),
    .alarmIrq(alarmIrq), .ovfIrq(ovfIrq), .invIrq(invIrq)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // run from a loaded state and compare every cycle (R2, R7, R9, R10)
  task automatic sweep(input int s, input int p0, input int a, input int ien,
                       input int n);
    logic [31:0] v;
    wr(3'd3, 32'h0);
    wr(3'd1, p0);
    wr(3'd0, s);
    wr(3'd2, a);
    wr(3'd4, ien);
    wr(3'd3, 32'h10);
    for (int k = 0; k <= n; k++) begin
      int ticks;
      bit expAlm;
      ticks  = (p0 + k) / STEP - p0 / STEP;
      expAlm = (a >= s) && (a < s + ticks);
      rd(3'd0, v); check("R2 seconds", v, (s + ticks) % SMOD);
      rd(3'd1, v); check("R2 prescaler", v, (p0 + k) % PMOD);
      check("R9 pulse", secPulse, (k >= 1) && ((p0 + k) % STEP == 0));
      rd(3'd3, v); check("R7 alarm flag", v[2], expAlm);
      check("R10 alarm irq", alarmIrq, expAlm && ien[0]);
      @(negedge clk);
    end
    wr(3'd3, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(3'd0, v); check("R1 seconds", v, 0);
    rd(3'd1, v); check("R1 prescaler", v, 0);
    rd(3'd2, v); check("R1 alarm", v, 0);
    rd(3'd3, v); check("R1 status", v, 1);
    rd(3'd4, v); check("R1 enables", v, 0);
    rd(3'd5, v); check("R1 control", v, 0);
    check("R1 outputs", {secPulse, alarmIrq, ovfIrq, invIrq}, 0);

    // R6 invalid: nothing advances, reads zero
    wr(3'd1, 7);
    wr(3'd3, 32'h10);
    idle(40);
    rd(3'd1, v); check("R6 prescaler reads zero", v, 0);
    rd(3'd0, v); check("R6 seconds reads zero", v, 0);
    rd(3'd3, v); check("R6 status while invalid", v, 32'h11);
    wr(3'd4, 4);
    check("R10 invalid irq on", invIrq, 1);
    wr(3'd3, 0);
    wr(3'd0, 20);
    rd(3'd3, v); check("R5 invalid cleared", v, 0);
    check("R10 invalid irq off", invIrq, 0);
    rd(3'd1, v); check("R6 prescaler held", v, 7);
    rd(3'd0, v); check("R4 seconds loaded", v, 20);

    // R4 stopped: no advance
    idle(50);
    rd(3'd0, v); check("R4 seconds stopped", v, 20);
    rd(3'd1, v); check("R4 prescaler stopped", v, 7);

    // sweeps
    sweep(10, 0, 12, 1, 70);
    wr(3'd2, 99);
    rd(3'd3, v); check("R7 alarm write clears", v[2], 0);
    sweep(100, 13, 100, 0, 40);
    sweep(0, 31, 200, 1, 20);
    sweep(40, 5, 30, 1, 45);

    // R3 writes ignored while running
    wr(3'd1, 0);
    wr(3'd0, 50);
    wr(3'd3, 32'h10);
    wr(3'd0, 99);
    wr(3'd1, 3);
    rd(3'd1, v); check("R3 prescaler write ignored", v, 4);
    rd(3'd0, v); check("R3 seconds write ignored", v, 50);
    wr(3'd3, 0);

    // R8 overflow at wrap
    wr(3'd1, 0);
    wr(3'd0, SMOD - 1);
    wr(3'd4, 2);
    wr(3'd3, 32'h10);
    for (int k = 0; k <= 30; k++) begin
      rd(3'd0, v); check("R8 seconds", v, (k < STEP) ? SMOD - 1 : 0);
      rd(3'd1, v); check("R6 prescaler after wrap", v, (k < STEP) ? k : 0);
      rd(3'd3, v); check("R8 overflow flag", v[1], k >= STEP);
      check("R10 overflow irq", ovfIrq, k >= STEP);
      check("R9 pulse at wrap", secPulse, k == STEP);
      @(negedge clk);
    end
    wr(3'd3, 0);
    wr(3'd0, 3);
    rd(3'd3, v); check("R5 overflow cleared", v, 0);
    rd(3'd1, v); check("R6 prescaler frozen value", v, STEP);
    rd(3'd0, v); check("R5 seconds after clear", v, 3);

    // R11 soft reset
    wr(3'd4, 7);
    wr(3'd2, 40);
    wr(3'd3, 32'h10);
    wr(3'd5, 1);
    wr(3'd2, 9);
    wr(3'd4, 3);
    wr(3'd3, 32'h10);
    rd(3'd5, v); check("R11 control holds", v, 1);
    rd(3'd2, v); check("R11 alarm held", v, 0);
    rd(3'd3, v); check("R11 status held", v, 1);
    rd(3'd4, v); check("R11 enables held", v, 0);
    check("R11 irqs low", {alarmIrq, ovfIrq, invIrq}, 0);
    begin
      int pulses = 0;
      for (int i = 0; i < 40; i++) begin
        if (secPulse) pulses++;
        @(negedge clk);
      end
      check("R11 no pulses", pulses, 0);
    end
    wr(3'd5, 0);
    rd(3'd5, v); check("R11 control cleared", v, 0);
    rd(3'd3, v); check("R11 invalid remains", v, 1);
    wr(3'd0, 7);
    rd(3'd1, v); check("R11 prescaler was reset", v, 0);
    rd(3'd0, v); check("R11 seconds usable", v, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule